// File: doc/BRIEF.md
# Bus-Mapped Register Bank with Three-Channel PWM

This block is a Wishbone slave with a 16-bit data bus. It holds a small word-addressed register map that a host reaches through an external bus master. The map holds two fixed identification words and a scratch word. It also has a port word: a write to it drives a 16-bit output port, and a read from it returns the levels of an input port and a set of switches. The remaining registers control a three-channel PWM unit. The channels share a clock prescaler and a period, and each channel has its own high time. Channels 1 and 2 drive the two LED outputs. Channel 0 is stored and can be read back, but it has no pin.

A two-state machine handles each bus access. In `BUS_IDLE`, a cycle with both CYC and STB high is taken: a write updates the addressed register, or a read latches the read data, and the machine moves to `BUS_ACK`. `BUS_ACK` drives ACK for that one cycle and always returns to `BUS_IDLE`. The PWM counter advances only on prescaler ticks. Each channel output is a compare of that counter against the channel's high time.

Top module: `wb_regbank_pwm`

## Requirements
- R1: A read at word address 0x0000 returns 0xDEAD, and a read at 0x0001 returns 0xBEEF.
- R2: Address 0x0002 is a scratch word. It reads 0x0000 after reset and returns the last value written.
- R3: Write data is merged byte by byte. Select bit 0 enables data bits 7:0 and select bit 1 enables bits 15:8. A write with both select bits low changes nothing.
- R4: A write to 0x0003 drives `port_out_o` from the edge that takes the access. `port_out_o` changes at no other time.
- R5: A read at 0x0003 returns `pin_i` in bits 7:0 and `switch_i` in bits 11:8, with zeros above.
- R6: A read at an unmapped address returns 0 and is still acknowledged. A write to 0x0000, 0x0001 or an unmapped address changes no register.
- R7: The divider (0x0008), the period (0x0009) and the high times of channels 0..2 (0x000A..0x000C) read back the values written to them.
- R8: ACK is high for exactly one cycle, in the cycle after a cycle in which the machine is in `BUS_IDLE` with CYC and STB both high. ACK is never high otherwise.
- R9: Reset clears every writable register, ACK, `port_out_o` and `led_o` to 0.
- R10: With divider D, the prescaler ticks once every D+1 clocks. On each tick the counter steps through 0..P-1 and then wraps to 0. Between ticks the counter holds. A full PWM cycle lasts P*(D+1) clocks.
- R11: A channel output is high while the counter is below its high time H. Within each full cycle it is high for min(H,P)*(D+1) clocks: H=0 keeps it low and H>=P keeps it high. With P=0 the counter stays at 0.
- R12: `led_o[0]` follows channel 1 and `led_o[1]` follows channel 2. Channel 0 drives no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Access strobe |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | ADDR_W (16) | Word address |
| wb_sel_i | input | 2 | Byte select |
| wb_dat_i | input | 16 | Write data |
| wb_dat_o | output | 16 | Read data, valid while ACK is high |
| wb_ack_o | output | 1 | Access acknowledge |
| port_out_o | output | 16 | Output port driven by writes to 0x0003 |
| pin_i | input | PIN_W (8) | Input port levels |
| switch_i | input | SW_W (4) | Switch levels |
| led_o | output | CH_N-1 (2) | PWM outputs of channels 1 and 2 |

## Verification
The bench sweeps the prescaler divider, the period and both LED high times. It includes H=0, H=P-1, H=P and H above P, and P=0. For each setting it counts the high clocks over one full PWM cycle after the outputs have settled, so the result does not depend on the phase the window starts at. Several faults would change that count: a counter that wraps at P instead of P-1, a prescaler off by one clock, or a compare written as `<=`. The bus corner cases get their own checks. A partial byte select that overwrote the whole word would corrupt the scratch value. A write that reached the identification words would change what they read back. An unmapped read that was dropped would leave ACK low. An ACK held for two cycles would be caught on the cycle after the acknowledge.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
    localparam int DW    = 16;
    localparam int SEL_W = DW / 8;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_ACK  = 1'b1
    } bus_state_t;

    localparam logic [DW-1:0] ID_WORD_A = 16'hDEAD;
    localparam logic [DW-1:0] ID_WORD_B = 16'hBEEF;

    localparam int A_ID_A   = 0;
    localparam int A_ID_B   = 1;
    localparam int A_SCR    = 2;
    localparam int A_PORT   = 3;
    localparam int A_DIV    = 8;
    localparam int A_PER    = 9;
    localparam int A_HI_LO  = 10;

    function automatic logic [DW-1:0] merge_bytes(
        input logic [DW-1:0]    old_v,
        input logic [DW-1:0]    new_v,
        input logic [SEL_W-1:0] sel
    );
        logic [DW-1:0] r;
        for (int b = 0; b < SEL_W; b++) begin
            r[b*8 +: 8] = sel[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/wb_bus_fsm.sv
module wb_bus_fsm
    import regbank_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cyc_i,
    input  logic stb_i,
    output logic ack_o,
    output logic take_o
);
    bus_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= BUS_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (cyc_i && stb_i) state_d = BUS_ACK;
            BUS_ACK:  state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        ack_o  = (state_q == BUS_ACK);
        take_o = (state_q == BUS_IDLE) && cyc_i && stb_i;
    end

    // R8
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !ack_o);

    // R8
    ack_after_req_chk: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> $past(cyc_i && stb_i));
endmodule

// File: rtl/wb_regfile.sv
module wb_regfile
    import regbank_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PIN_W  = 8,
    parameter int SW_W   = 4,
    parameter int CH_N   = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   take_i,
    input  logic                   we_i,
    input  logic [ADDR_W-1:0]      adr_i,
    input  logic [SEL_W-1:0]       sel_i,
    input  logic [DW-1:0]          dat_i,
    input  logic [PIN_W-1:0]       pin_i,
    input  logic [SW_W-1:0]        switch_i,
    output logic [DW-1:0]          rd_o,
    output logic [DW-1:0]          port_o,
    output logic [DW-1:0]          div_o,
    output logic [DW-1:0]          per_o,
    output logic [(CH_N-1)*DW-1:0] hi_drv_o
);
    logic [DW-1:0] scr_q, port_q, div_q, per_q, rd_q, rd_mux;
    logic [DW-1:0] hi_q [CH_N];

    always_comb begin
        rd_mux = '0;
        if (adr_i == ADDR_W'(A_ID_A)) rd_mux = ID_WORD_A;
        if (adr_i == ADDR_W'(A_ID_B)) rd_mux = ID_WORD_B;
        if (adr_i == ADDR_W'(A_SCR))  rd_mux = scr_q;
        if (adr_i == ADDR_W'(A_PORT)) rd_mux = DW'({switch_i, pin_i});
        if (adr_i == ADDR_W'(A_DIV))  rd_mux = div_q;
        if (adr_i == ADDR_W'(A_PER))  rd_mux = per_q;
        for (int i = 0; i < CH_N; i++) begin
            if (adr_i == ADDR_W'(A_HI_LO + i)) rd_mux = hi_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scr_q  <= '0;
            port_q <= '0;
            div_q  <= '0;
            per_q  <= '0;
            rd_q   <= '0;
            for (int i = 0; i < CH_N; i++) hi_q[i] <= '0;
        end else if (take_i) begin
            if (we_i) begin
                if (adr_i == ADDR_W'(A_SCR))  scr_q  <= merge_bytes(scr_q, dat_i, sel_i);
                if (adr_i == ADDR_W'(A_PORT)) port_q <= merge_bytes(port_q, dat_i, sel_i);
                if (adr_i == ADDR_W'(A_DIV))  div_q  <= merge_bytes(div_q, dat_i, sel_i);
                if (adr_i == ADDR_W'(A_PER))  per_q  <= merge_bytes(per_q, dat_i, sel_i);
                for (int i = 0; i < CH_N; i++) begin
                    if (adr_i == ADDR_W'(A_HI_LO + i))
                        hi_q[i] <= merge_bytes(hi_q[i], dat_i, sel_i);
                end
            end else begin
                rd_q <= rd_mux;
            end
        end
    end

    assign rd_o   = rd_q;
    assign port_o = port_q;
    assign div_o  = div_q;
    assign per_o  = per_q;

    for (genvar g = 1; g < CH_N; g++) begin : g_drv
        assign hi_drv_o[(g-1)*DW +: DW] = hi_q[g];
    end

    // R4
    port_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(take_i && we_i) |-> $stable(port_q));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import regbank_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] div_i,
    input  logic [DW-1:0] per_i,
    output logic [DW-1:0] ctr_o
);
    logic [DW-1:0] pre_q, ctr_q;
    logic          tick;
    logic [DW:0]   ctr_next;

    assign tick     = (pre_q >= div_i);
    assign ctr_next = {1'b0, ctr_q} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            ctr_q <= '0;
        end else begin
            pre_q <= tick ? '0 : pre_q + 1'b1;
            if (tick) begin
                if (ctr_next >= {1'b0, per_i}) ctr_q <= '0;
                else                           ctr_q <= ctr_next[DW-1:0];
            end
        end
    end

    assign ctr_o = ctr_q;

    // R10
    ctr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(ctr_q));

    // R11
    ctr_range_chk: assert property (@(posedge clk) disable iff (rst)
        (per_i != '0 && $stable(per_i) && $past(ctr_q) < per_i) |-> ctr_q < per_i);
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
    import regbank_pkg::*;
(
    input  logic [DW-1:0] ctr_i,
    input  logic [DW-1:0] high_i,
    output logic          out_o
);
    assign out_o = (ctr_i < high_i);
endmodule

// File: rtl/wb_regbank_pwm.sv
module wb_regbank_pwm
    import regbank_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PIN_W  = 8,
    parameter int SW_W   = 4,
    parameter int CH_N   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wb_cyc_i,
    input  logic              wb_stb_i,
    input  logic              wb_we_i,
    input  logic [ADDR_W-1:0] wb_adr_i,
    input  logic [SEL_W-1:0]  wb_sel_i,
    input  logic [DW-1:0]     wb_dat_i,
    output logic [DW-1:0]     wb_dat_o,
    output logic              wb_ack_o,
    output logic [DW-1:0]     port_out_o,
    input  logic [PIN_W-1:0]  pin_i,
    input  logic [SW_W-1:0]   switch_i,
    output logic [CH_N-2:0]   led_o
);
    localparam int LED_N = CH_N - 1;

    logic                take;
    logic [DW-1:0]       div_w, per_w, ctr_w;
    logic [LED_N*DW-1:0] hi_w;

    wb_bus_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .cyc_i  (wb_cyc_i),
        .stb_i  (wb_stb_i),
        .ack_o  (wb_ack_o),
        .take_o (take)
    );

    wb_regfile #(
        .ADDR_W (ADDR_W),
        .PIN_W  (PIN_W),
        .SW_W   (SW_W),
        .CH_N   (CH_N)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .take_i   (take),
        .we_i     (wb_we_i),
        .adr_i    (wb_adr_i),
        .sel_i    (wb_sel_i),
        .dat_i    (wb_dat_i),
        .pin_i    (pin_i),
        .switch_i (switch_i),
        .rd_o     (wb_dat_o),
        .port_o   (port_out_o),
        .div_o    (div_w),
        .per_o    (per_w),
        .hi_drv_o (hi_w)
    );

    pwm_timebase u_tb (
        .clk   (clk),
        .rst   (rst),
        .div_i (div_w),
        .per_i (per_w),
        .ctr_o (ctr_w)
    );

    for (genvar g = 0; g < LED_N; g++) begin : g_led
        pwm_compare u_cmp (
            .ctr_i  (ctr_w),
            .high_i (hi_w[g*DW +: DW]),
            .out_o  (led_o[g])
        );
    end
endmodule

// File: tb/wb_regbank_pwm_tb_top.sv
`timescale 1ns/1ps
module wb_regbank_pwm_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [15:0] adr = '0, dat = '0;
    logic [1:0]  sel = '0;
    logic [15:0] dat_o, port_out;
    logic        ack;
    logic [7:0]  pin = '0;
    logic [3:0]  sw = '0;
    logic [1:0]  led;

    int errs   = 0;
    int checks = 0;
    logic [15:0] rd;

    always #2.5 clk = ~clk;

    wb_regbank_pwm dut_i (
        .clk(clk), .rst(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
        .wb_adr_i(adr), .wb_sel_i(sel), .wb_dat_i(dat), .wb_dat_o(dat_o),
        .wb_ack_o(ack), .port_out_o(port_out), .pin_i(pin), .switch_i(sw),
        .led_o(led)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [15:0] a, input logic [15:0] d,
                       input logic [1:0] s, output logic [15:0] q);
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = w; adr = a; dat = d; sel = s;
        @(posedge clk); #1;
        chk("R8 ack after request", ack, 1'b1);
        q = dat_o;
        @(negedge clk);
        cyc = 1'b0; stb = 1'b0; we = 1'b0;
        @(posedge clk); #1;
        chk("R8 ack lasts one cycle", ack, 1'b0);
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        logic [15:0] unused_q;
        acc(1'b1, a, d, 2'b11, unused_q);
    endtask

    task automatic rdw(input logic [15:0] a, output logic [15:0] q);
        acc(1'b0, a, 16'h0, 2'b11, q);
    endtask

    function automatic int exp_high(input int h, input int p, input int d);
        return ((h >= p) ? p : h) * (d + 1);
    endfunction

    task automatic pwm_run(input int d, input int p, input int h1, input int h2);
        int n, c1, c2;
        wr(16'h0008, 16'(d));
        wr(16'h0009, 16'(p));
        wr(16'h000B, 16'(h1));
        wr(16'h000C, 16'(h2));
        n = (p == 0) ? 16 : p * (d + 1);
        repeat (3 * n + 4) @(negedge clk);
        c1 = 0; c2 = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            c1 += int'(led[0]);
            c2 += int'(led[1]);
        end
        if (p == 0) begin
            chk("R11 P=0 led0 constant", c1, (h1 > 0) ? n : 0);
            chk("R11 P=0 led1 constant", c2, (h2 > 0) ? n : 0);
        end else begin
            chk("R10 R11 R12 led0 high clocks per cycle", c1, exp_high(h1, p, d));
            chk("R10 R11 R12 led1 high clocks per cycle", c2, exp_high(h2, p, d));
        end
    endtask

    initial begin
        #(200000 * 5);
        errs++;
        checks++;
        $display("FAIL R8 watchdog act=hung exp=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int hv [5];
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        // R9 reset state
        chk("R9 ack after reset", ack, 1'b0);
        chk("R9 port_out after reset", port_out, 16'h0);
        chk("R9 led after reset", led, 2'b00);

        // R8 no ack without strobe
        @(negedge clk); cyc = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 no ack with CYC only", ack, 1'b0);
        cyc = 1'b0;

        // R1
        rdw(16'h0000, rd); chk("R1 id word 0", rd, 16'hDEAD);
        rdw(16'h0001, rd); chk("R1 id word 1", rd, 16'hBEEF);

        // R2 R9
        rdw(16'h0002, rd); chk("R2 R9 scratch after reset", rd, 16'h0000);
        wr(16'h0002, 16'h1234);
        rdw(16'h0002, rd); chk("R2 scratch readback", rd, 16'h1234);

        // R3 byte select
        acc(1'b1, 16'h0002, 16'hABCD, 2'b01, rd);
        rdw(16'h0002, rd); chk("R3 low byte only", rd, 16'h12CD);
        acc(1'b1, 16'h0002, 16'hEF00, 2'b10, rd);
        rdw(16'h0002, rd); chk("R3 high byte only", rd, 16'hEFCD);
        acc(1'b1, 16'h0002, 16'h0000, 2'b00, rd);
        rdw(16'h0002, rd); chk("R3 no select no change", rd, 16'hEFCD);

        // R4
        wr(16'h0003, 16'h5A3C);
        chk("R4 port out after write", port_out, 16'h5A3C);
        rdw(16'h0002, rd);
        chk("R4 port out held over other access", port_out, 16'h5A3C);

        // R5
        pin = 8'hA5; sw = 4'h9;
        rdw(16'h0003, rd); chk("R5 port read", rd, 16'h09A5);
        pin = 8'h3C; sw = 4'h6;
        rdw(16'h0003, rd); chk("R5 port read second pattern", rd, 16'h063C);

        // R6
        wr(16'h0000, 16'h0000);
        rdw(16'h0000, rd); chk("R6 write to id ignored", rd, 16'hDEAD);
        wr(16'h0001, 16'h1111);
        rdw(16'h0001, rd); chk("R6 write to id1 ignored", rd, 16'hBEEF);
        wr(16'h0005, 16'hFFFF);
        rdw(16'h0005, rd); chk("R6 unmapped read zero", rd, 16'h0000);
        rdw(16'h0002, rd); chk("R6 unmapped write left scratch", rd, 16'hEFCD);
        chk("R6 unmapped write left port", port_out, 16'h5A3C);
        rdw(16'h0100, rd); chk("R6 far unmapped read zero", rd, 16'h0000);

        // R7
        wr(16'h000A, 16'h0077);
        rdw(16'h000A, rd); chk("R7 channel 0 high readback", rd, 16'h0077);
        chk("R12 channel 0 drives no led", led, 2'b00);
        wr(16'h0008, 16'h0004);
        rdw(16'h0008, rd); chk("R7 divider readback", rd, 16'h0004);
        wr(16'h0009, 16'h0800);
        rdw(16'h0009, rd); chk("R7 period readback", rd, 16'h0800);
        wr(16'h000B, 16'h0080);
        rdw(16'h000B, rd); chk("R7 channel 1 high readback", rd, 16'h0080);
        wr(16'h000C, 16'h0081);
        rdw(16'h000C, rd); chk("R7 channel 2 high readback", rd, 16'h0081);

        // R10 R11 R12 sweep
        foreach (hv[k]) hv[k] = 0;
        for (int d = 0; d < 4; d++) begin
            if (d == 2) continue;
            for (int pi = 0; pi < 3; pi++) begin
                int p;
                p = (pi == 0) ? 1 : ((pi == 1) ? 3 : 6);
                hv[0] = 0; hv[1] = 1; hv[2] = p - 1; hv[3] = p; hv[4] = p + 2;
                for (int k = 0; k < 5; k++) begin
                    pwm_run(d, p, hv[k], hv[(k + 2) % 5]);
                end
            end
        end

        // R11 period zero
        pwm_run(1, 0, 5, 0);
        pwm_run(0, 0, 0, 3);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule